// File: doc/BRIEF.md
# Parallel Root Counter and Candidate Polynomial Selector

This block sits at the back end of a soft-decision decoder for a binary cyclic code over GF(2^10). It receives up to eight candidate error-locator polynomials, one per test pattern. Each candidate is given as four field coefficients R, A, B and C and a 2-bit degree code. The block sweeps all code positions for every candidate in the same clock. At each position it counts how often the candidate's locator equation is satisfied. It then checks the root count against the degree the candidate claims, and reports which candidate to use. No iteration is involved.

A start strobe captures all coefficients and degree codes. For N clocks, one clock per position, each candidate lane compares R with A·x + B·x^2 + C·x^3 for the current evaluation point x. Each lane steps its A, B and C terms by constant multipliers, the inverse of alpha, its square and its cube. When the sweep ends, a fixed-priority picker returns the lowest-numbered consistent candidate and a one-cycle done pulse. If no candidate is consistent, the picker raises a failure flag.

Top module: `poly_root_selector`

## Requirements
- R1: Candidate j takes its coefficients from bits [j*10 +: 10] of `cand_r`, `cand_a`, `cand_b` and `cand_c`, and its degree code from bits [j*2 +: 2] of `cand_deg`. A `start` sampled high while idle captures all of them. `done` is high for exactly one cycle, after the N-th rising edge that follows the capturing edge.
- R2: Sweep step j (j = 0 … N-1) evaluates the point x = alpha^(-j), where alpha is a root of x^10+x^3+1. A candidate gets one count at every step where R == A·x + B·x^2 + C·x^3 in GF(2^10).
- R3: A root at alpha^(-j) with j ≥ N is never counted. A root at j = N-1 is counted.
- R4: The per-candidate count saturates at 3. A fourth match marks the candidate as violating, whatever its degree code.
- R5: Degree code 3 is consistent only with a count of 3, and code 2 only with a count of 2. Code 0 is consistent with a count of 0 or 1. Code 1 is never consistent.
- R6: `sel_idx` is the lowest-numbered consistent candidate. Candidate 0 has the highest priority.
- R7: When all candidates are inconsistent, `sel_idx` is 0 and `decode_fail` is 1. Otherwise `decode_fail` is 0.
- R8: A `start` during a sweep is ignored. The running sweep keeps its timing and its captured inputs.
- R9: After reset, `done` is 0, `sel_idx` is 0 and `decode_fail` is 0.
- R10: `sel_idx` and `decode_fail` hold their result after `done` until the next accepted `start`, even if the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture candidates and begin a sweep |
| cand_r | input | 80 | Constant terms R, 10 bits per candidate |
| cand_a | input | 80 | Linear coefficients A |
| cand_b | input | 80 | Quadratic coefficients B |
| cand_c | input | 80 | Cubic coefficients C |
| cand_deg | input | 16 | Degree codes, 2 bits per candidate |
| done | output | 1 | One-cycle pulse at the end of the sweep |
| sel_idx | output | 3 | Chosen candidate index |
| decode_fail | output | 1 | No candidate is consistent |

## Verification
The assertions assume that `start` is never high in the same cycle as reset release. They also assume that a run is judged only from its `done` pulse onward, because the picker output follows the lane counts while a sweep is in progress. The bench drives `start` only on the falling edge and reads results only after `done`. It builds each candidate from roots chosen at known sweep steps, including steps beyond the swept range, so the expected count is known without modelling the lanes. One scenario deliberately raises `start` in the middle of a sweep, to exercise the case in which the assumption that `start` has no effect must hold at the ports.

// File: rtl/prs_pkg.sv
package prs_pkg;
  localparam int GF_M = 10;
  // low part of x^10 + x^3 + 1 (includes the constant term)
  localparam logic [GF_M-1:0] GF_POLY = 10'h009;

  typedef enum logic [1:0] {
    DEG_LOW   = 2'd0,
    DEG_BAD   = 2'd1,
    DEG_TWO   = 2'd2,
    DEG_THREE = 2'd3
  } deg_code_e;

  // Polynomial-basis product, most significant multiplier bit first
  function automatic logic [GF_M-1:0] gf_mul(input logic [GF_M-1:0] a,
                                             input logic [GF_M-1:0] b);
    logic [GF_M-1:0] p;
    p = '0;
    for (int i = GF_M - 1; i >= 0; i--) begin
      p = {p[GF_M-2:0], 1'b0} ^ (p[GF_M-1] ? GF_POLY : '0);
      if (b[i]) p = p ^ a;
    end
    return p;
  endfunction

  // alpha^-1 for a modulus with a constant term: (poly - 1) / x
  function automatic logic [GF_M-1:0] gf_inv_alpha();
    return {1'b1, GF_POLY[GF_M-1:1]};
  endfunction

  // Consistency rule between claimed degree and root count
  function automatic logic deg_ok(input deg_code_e d, input logic [1:0] cnt);
    case (d)
      DEG_THREE: return cnt == 2'd3;
      DEG_TWO:   return cnt == 2'd2;
      DEG_LOW:   return cnt <= 2'd1;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/prs_sweep_ctrl.sv
module prs_sweep_ctrl #(
  parameter int N = 1020
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic done
);
  localparam int CW = $clog2(N);

  logic          busy;
  logic [CW-1:0] pos;
  logic          last_step;

  assign load      = start & ~busy;
  assign step      = busy;
  assign last_step = busy && (pos == CW'(N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pos  <= '0;
      done <= 1'b0;
    end else begin
      done <= last_step;
      if (load) begin
        busy <= 1'b1;
        pos  <= '0;
      end else if (busy) begin
        if (last_step) busy <= 1'b0;
        else           pos  <= pos + 1'b1;
      end
    end
  end

  // independent run-length counter for the checks
  logic [CW:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (load) run_len <= '0;
    else if (step) run_len <= run_len + 1'b1;
  end

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R1
  sweep_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> run_len == (CW+1)'(N));
  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last_step) |=> (busy && pos == $past(pos) + 1'b1));
endmodule

// File: rtl/prs_lane.sv
module prs_lane
  import prs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step,
  input  logic [GF_M-1:0] in_r,
  input  logic [GF_M-1:0] in_a,
  input  logic [GF_M-1:0] in_b,
  input  logic [GF_M-1:0] in_c,
  input  logic [1:0]      in_deg,
  output logic            violate
);
  localparam logic [GF_M-1:0] STEP_A = gf_inv_alpha();
  localparam logic [GF_M-1:0] STEP_B = gf_mul(STEP_A, STEP_A);
  localparam logic [GF_M-1:0] STEP_C = gf_mul(STEP_B, STEP_A);

  logic [GF_M-1:0] term_a, term_b, term_c, const_r;
  deg_code_e       deg_q;
  logic [1:0]      roots;
  logic            overflow;
  logic            hit;

  assign hit = step && (const_r == (term_a ^ term_b ^ term_c));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_a   <= '0;
      term_b   <= '0;
      term_c   <= '0;
      const_r  <= '0;
      deg_q    <= DEG_LOW;
      roots    <= '0;
      overflow <= 1'b0;
    end else if (load) begin
      term_a   <= in_a;
      term_b   <= in_b;
      term_c   <= in_c;
      const_r  <= in_r;
      deg_q    <= deg_code_e'(in_deg);
      roots    <= '0;
      overflow <= 1'b0;
    end else if (step) begin
      term_a <= gf_mul(term_a, STEP_A);
      term_b <= gf_mul(term_b, STEP_B);
      term_c <= gf_mul(term_c, STEP_C);
      if (hit) begin
        if (roots == 2'd3) overflow <= 1'b1;
        else               roots    <= roots + 1'b1;
      end
    end
  end

  assign violate = overflow | ~deg_ok(deg_q, roots);

  // R2
  count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> roots >= $past(roots));
  // R4
  overflow_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> ($past(roots) == 2'd3 && $past(hit)));
  // R4
  overflow_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> violate);
endmodule

// File: rtl/prs_pick.sv
module prs_pick #(
  parameter int NC = 8,
  localparam int IW = $clog2(NC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NC-1:0] violate,
  output logic [IW-1:0] sel,
  output logic          fail
);
  always_comb begin
    sel  = '0;
    fail = 1'b1;
    for (int i = NC - 1; i >= 0; i--) begin
      if (!violate[i]) begin
        sel  = IW'(i);
        fail = 1'b0;
      end
    end
  end

  // R6
  pick_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fail |-> !violate[sel]);
  // R6
  pick_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fail |-> $countones(violate & ((NC'(1) << sel) - NC'(1))) == int'(sel));
  // R7
  fail_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (sel == '0 && &violate));
endmodule

// File: rtl/poly_root_selector.sv
module poly_root_selector
  import prs_pkg::*;
#(
  parameter int N  = 1020,
  parameter int NC = 8,
  localparam int IW = $clog2(NC),
  localparam int CB = NC * GF_M
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CB-1:0] cand_r,
  input  logic [CB-1:0] cand_a,
  input  logic [CB-1:0] cand_b,
  input  logic [CB-1:0] cand_c,
  input  logic [2*NC-1:0] cand_deg,
  output logic          done,
  output logic [IW-1:0] sel_idx,
  output logic          decode_fail
);
  logic          load_ev;
  logic          step_ev;
  logic [NC-1:0] violate_vec;

  prs_sweep_ctrl #(.N(N)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (load_ev),
    .step  (step_ev),
    .done  (done)
  );

  for (genvar g = 0; g < NC; g++) begin : g_lane
    prs_lane u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load_ev),
      .step    (step_ev),
      .in_r    (cand_r[g*GF_M +: GF_M]),
      .in_a    (cand_a[g*GF_M +: GF_M]),
      .in_b    (cand_b[g*GF_M +: GF_M]),
      .in_c    (cand_c[g*GF_M +: GF_M]),
      .in_deg  (cand_deg[g*2 +: 2]),
      .violate (violate_vec[g])
    );
  end

  prs_pick #(.NC(NC)) u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .violate (violate_vec),
    .sel     (sel_idx),
    .fail    (decode_fail)
  );

  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_ev && !load_ev && !$past(step_ev)) |=> $stable(sel_idx) && $stable(decode_fail));
endmodule

// File: tb/test_poly_root_selector.sv
`timescale 1ns/1ps
module test_poly_root_selector;
  localparam int N  = 1020;
  localparam int NC = 8;
  localparam int M  = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [NC*M-1:0] cand_r, cand_a, cand_b, cand_c;
  logic [2*NC-1:0] cand_deg;
  logic done;
  logic [2:0] sel_idx;
  logic decode_fail;

  logic [M-1:0] vr[NC], va[NC], vb[NC], vc[NC];
  logic [1:0]   vd[NC];

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  poly_root_selector i_poly_root_selector (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cand_r(cand_r), .cand_a(cand_a), .cand_b(cand_b), .cand_c(cand_c),
    .cand_deg(cand_deg), .done(done), .sel_idx(sel_idx), .decode_fail(decode_fail)
  );

  // field arithmetic, shift-the-multiplicand form
  function automatic logic [M-1:0] xtime(input logic [M-1:0] v);
    return v[M-1] ? ({v[M-2:0], 1'b0} ^ 10'h009) : {v[M-2:0], 1'b0};
  endfunction
  function automatic logic [M-1:0] fmul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] acc = '0;
    logic [M-1:0] t = a;
    for (int i = 0; i < M; i++) begin
      if (b[i]) acc ^= t;
      t = xtime(t);
    end
    return acc;
  endfunction
  // point swept at step j: alpha^(1023-j)
  function automatic logic [M-1:0] pt(input int j);
    logic [M-1:0] v = 10'd1;
    int e = (1023 - j) % 1023;
    for (int i = 0; i < e; i++) v = xtime(v);
    return v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_const(input int k, input logic [1:0] d); // no roots
    vr[k] = 10'd1; va[k] = '0; vb[k] = '0; vc[k] = '0; vd[k] = d;
  endtask
  task automatic set_lin(input int k, input int j1, input logic [1:0] d);
    vr[k] = pt(j1); va[k] = 10'd1; vb[k] = '0; vc[k] = '0; vd[k] = d;
  endtask
  task automatic set_quad(input int k, input int j1, input int j2, input logic [1:0] d);
    logic [M-1:0] x1 = pt(j1), x2 = pt(j2);
    vr[k] = fmul(x1, x2); va[k] = x1 ^ x2; vb[k] = 10'd1; vc[k] = '0; vd[k] = d;
  endtask
  task automatic set_cubic(input int k, input int j1, input int j2, input int j3,
                           input logic [1:0] d);
    logic [M-1:0] x1 = pt(j1), x2 = pt(j2), x3 = pt(j3);
    vr[k] = fmul(fmul(x1, x2), x3);
    va[k] = fmul(x1, x2) ^ fmul(x1, x3) ^ fmul(x2, x3);
    vb[k] = x1 ^ x2 ^ x3;
    vc[k] = 10'd1;
    vd[k] = d;
  endtask
  task automatic fill(input logic [1:0] d);
    for (int k = 0; k < NC; k++) set_const(k, d);
  endtask
  task automatic drive();
    for (int k = 0; k < NC; k++) begin
      cand_r[k*M +: M] = vr[k]; cand_a[k*M +: M] = va[k];
      cand_b[k*M +: M] = vb[k]; cand_c[k*M +: M] = vc[k];
      cand_deg[k*2 +: 2] = vd[k];
    end
  endtask
  task automatic kick();
    @(negedge clk); drive(); start = 1;
    @(posedge clk);
    @(negedge clk); start = 0;
  endtask
  task automatic finish_sweep(input int edges_done, input string req);
    repeat (N - 1 - edges_done) @(posedge clk);
    @(negedge clk); check({req, " done early"}, done, 0);
    @(posedge clk);
    @(negedge clk); check({req, " done"}, done, 1);
  endtask
  task automatic run(input string req, input int exp_sel, input int exp_fail);
    kick();
    finish_sweep(0, req);
    check({req, " sel"}, sel_idx, exp_sel);
    check({req, " fail"}, decode_fail, exp_fail);
    @(negedge clk); check({req, " done single"}, done, 0);
  endtask

  task automatic t_reset();
    check("R9 done", done, 0);
    check("R9 sel", sel_idx, 0);
    check("R9 fail", decode_fail, 0);
  endtask
  task automatic t_cubic_full(); // R2 R5
    fill(2'd1); set_cubic(0, 3, 400, 1019, 2'd3);
    run("R2 cubic three roots", 0, 0);
  endtask
  task automatic t_edge_roots(); // R3: step 1019 counted, 1020 not
    fill(2'd1);
    set_cubic(0, 0, 1019, 1020, 2'd3);
    set_cubic(1, 0, 1019, 1020, 2'd2);
    run("R3 edge root", 1, 0);
  endtask
  task automatic t_degree_codes(); // R5
    fill(2'd1);
    set_lin(0, 7, 2'd1);
    set_lin(1, 7, 2'd0);
    run("R5 code1 vs code0 one root", 1, 0);
    fill(2'd1);
    set_quad(0, 11, 900, 2'd3);
    set_quad(1, 11, 900, 2'd2);
    run("R5 quad two roots", 1, 0);
    fill(2'd1);
    set_const(3, 2'd0);
    run("R5 code0 zero roots", 3, 0);
  endtask
  task automatic t_saturate(); // R4
    fill(2'd1);
    vr[0] = '0; va[0] = '0; vb[0] = '0; vc[0] = '0; vd[0] = 2'd3;
    set_cubic(1, 50, 60, 70, 2'd3);
    run("R4 saturate overflow", 1, 0);
  endtask
  task automatic t_priority(); // R6
    fill(2'd1);
    set_const(5, 2'd0); set_quad(6, 1, 2, 2'd2);
    run("R6 lowest valid", 5, 0);
    fill(2'd1);
    set_lin(7, 1000, 2'd0);
    run("R6 last only", 7, 0);
  endtask
  task automatic t_all_bad(); // R7
    fill(2'd1);
    set_cubic(2, 5, 6, 1021, 2'd3);
    run("R7 all violate", 0, 1);
  endtask
  task automatic t_restart_and_hold(); // R8 R10
    fill(2'd1); set_const(2, 2'd0);
    kick();
    repeat (100) @(posedge clk);
    @(negedge clk); fill(2'd1); drive(); start = 1;
    @(posedge clk);
    @(negedge clk); start = 0;
    finish_sweep(101, "R8 ignored start");
    check("R8 sel", sel_idx, 2);
    check("R8 fail", decode_fail, 0);
    repeat (30) @(negedge clk);
    check("R10 sel held", sel_idx, 2);
    check("R10 fail held", decode_fail, 0);
  endtask

  initial begin
    fill(2'd0); drive();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_cubic_full();
    t_edge_roots();
    t_degree_codes();
    t_saturate();
    t_priority();
    t_all_bad();
    t_restart_and_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule